// File: doc/BRIEF.md
# Forward Channel Sync and Status Tracker

This block watches a received serial bit stream, one bit per qualified clock, for a fixed synchronisation pattern. A candidate is accepted when the number of bit positions in which the last received bits differ from the pattern does not exceed a limit set on an input. Each accepted pattern locks the tracker and records its error count. It also restarts a frame position counter, and that counter locates two kinds of status bits in the frame that follows. One is a decode-failure flag from the remote station. The other is a run of busy/idle bits, which are reduced to a single busy indication by majority vote.

Lock is lost when more than a programmed number of bits (420 by default) go by without an accepted pattern. Acceptances, busy/idle updates and loss of lock each set a sticky interrupt flag. Software clears a flag by writing 1 to it. A single interrupt line is the OR of the enabled flags.

Top module: `fwd_sync_tracker`

## Requirements
- R1: With at least SYNC_LEN qualified bits received since reset, a qualified bit completes an acceptable pattern when the last SYNC_LEN bits (oldest first, compared against SYNC_WORD, default 6'b101101) differ in no more than `err_limit` positions. The pattern is then accepted: status bit 7 (lock) is 1 after that clock edge and flag bit 0 (pattern seen) is set.
- R2: A pattern with more mismatches than `err_limit` changes neither status bits 2..0 nor flag bit 0.
- R3: Status bits 2..0 hold the mismatch count of the most recently accepted pattern, saturated at 7.
- R4: The first bit after an accepted pattern has frame position 0. If the bit at position TIMEOUT (default 420) arrives while locked and is not itself an accepted pattern, status bit 7 clears and flag bit 2 (lock lost). Bits up to position TIMEOUT-1 keep the lock.
- R5: While locked, the bit at position DEC_OFS (default 8) is copied to status bit 6 (1 = remote decode failure). Status bit 6 does not change while unlocked.
- R6: While locked, the bits at positions IDLE_OFS + k*IDLE_GAP (defaults 12 and 6, k = 0..4) are shifted one by one into a five-deep history. After each shift, status bit 5 becomes the majority of the history (1 = busy, 0 = idle) and flag bit 1 (busy/idle update) is set. Status bit 5 does not change while unlocked.
- R7: When a pattern is accepted while unlocked, status bit 5 takes the majority of the retained history and flag bit 1 is set. The history is all zero after reset, so the first lock reads idle.
- R8: Flags are sticky. A 1 on `irq_clr` bit i clears flag i on that edge, but a flag that is being set on the same edge stays set.
- R9: `irq` is 1 exactly when some flag bit and the matching `irq_en` bit are both 1.
- R10: After reset, status, flags and `irq` are all zero. Status bits 4 and 3 are always zero.
- R11: Clocks with `bit_valid` low change no status bit and no flag, whatever `bit_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | Qualifies `bit_in` on this clock |
| bit_in | input | 1 | Received serial bit |
| err_limit | input | 3 | Largest mismatch count that is still accepted |
| irq_en | input | 3 | Per-flag interrupt enable |
| irq_clr | input | 3 | Write-1-to-clear strobe per flag |
| status | output | 8 | {lock, decode fail, busy, 0, 0, mismatch count[2:0]} |
| irq_flags | output | 3 | {lock lost, busy/idle update, pattern seen} |
| irq | output | 1 | OR of enabled flags |

## Verification
The embedded properties assume that all frame slot positions lie below the timeout. They also assume that `err_limit` stays constant during the cycle of any qualified bit. The stimulus only changes the limit between bits. Frames are built from isolated ones on a zero background, and the limit is at most 1 wherever a frame is in flight. As a result, no shifted alignment of pattern and payload lands within the limit, and every acceptance the directed checks expect is a deliberate one. A bit-exact reference model in the bench follows every qualified bit, so any unintended acceptance would still be reported.

// File: rtl/fst_pkg.sv
package fst_pkg;

   localparam int ERR_W    = 3;
   localparam int ERR_MAX  = 7;
   localparam int FLAG_W   = 3;

   localparam int FL_SEEN  = 0;
   localparam int FL_IDLE  = 1;
   localparam int FL_LOST  = 2;

   typedef struct packed {
      logic             lock;
      logic             dec_fail;
      logic             busy;
      logic [1:0]       rsvd;
      logic [ERR_W-1:0] errs;
   } stat_t;

endpackage

// File: rtl/fst_sync_detect.sv
module fst_sync_detect #(
   parameter int                  SYNC_LEN  = 6,
   parameter logic [SYNC_LEN-1:0] SYNC_WORD = 6'b101101
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bit_valid,
   input  logic                     bit_in,
   input  logic [fst_pkg::ERR_W-1:0] err_limit,
   output logic                     accept,
   output logic [fst_pkg::ERR_W-1:0] err_cnt
);
   import fst_pkg::*;

   localparam int HIST_W = SYNC_LEN - 1;
   localparam int FILL_W = $clog2(SYNC_LEN);
   localparam int RAW_W  = $clog2(SYNC_LEN + 1);

   if (SYNC_LEN < 2) begin : g_len_bad
      $error("SYNC_LEN must be at least 2");
   end

   logic [HIST_W-1:0]   hist_q;
   logic [FILL_W-1:0]   fill_q;
   logic [SYNC_LEN-1:0] cand;
   logic [SYNC_LEN-1:0] diff;
   logic [RAW_W-1:0]    raw_cnt;
   logic                full;

   assign cand = {hist_q, bit_in};
   assign diff = cand ^ SYNC_WORD;
   assign full = (fill_q == FILL_W'(HIST_W));

   always_comb begin
      raw_cnt = '0;
      for (int i = 0; i < SYNC_LEN; i++) begin
         raw_cnt = raw_cnt + RAW_W'(diff[i]);
      end
   end

   if (RAW_W > ERR_W) begin : g_sat
      assign err_cnt = (raw_cnt > RAW_W'(ERR_MAX)) ? ERR_W'(ERR_MAX) : ERR_W'(raw_cnt);
   end else begin : g_nosat
      assign err_cnt = ERR_W'(raw_cnt);
   end

   assign accept = bit_valid && full && (err_cnt <= err_limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         fill_q <= '0;
      end else if (bit_valid) begin
         hist_q <= cand[HIST_W-1:0];
         if (!full) fill_q <= fill_q + FILL_W'(1);
      end
   end

   // R1
   no_early_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_q == '0) |-> !accept);

endmodule

// File: rtl/fst_frame_timer.sv
module fst_frame_timer #(
   parameter int TIMEOUT    = 420,
   parameter int DEC_OFS    = 8,
   parameter int IDLE_OFS   = 12,
   parameter int IDLE_GAP   = 6,
   parameter int IDLE_VOTES = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid,
   input  logic accept,
   output logic locked,
   output logic acquire,
   output logic lost,
   output logic dec_stb,
   output logic idle_stb
);
   localparam int POS_MAX = TIMEOUT + 1;
   localparam int POS_W   = $clog2(POS_MAX + 1);
   localparam int LAST_SLOT = IDLE_OFS + (IDLE_VOTES - 1) * IDLE_GAP;

   if (DEC_OFS >= TIMEOUT || LAST_SLOT >= TIMEOUT) begin : g_ofs_bad
      $error("frame slots must lie below TIMEOUT");
   end
   if (IDLE_GAP < 1) begin : g_gap_bad
      $error("IDLE_GAP must be positive");
   end

   logic [POS_W-1:0]      pos_q;
   logic                  locked_q;
   logic                  run;
   logic [IDLE_VOTES-1:0] slot_hit;

   assign run = bit_valid && locked_q && !accept;

   for (genvar k = 0; k < IDLE_VOTES; k++) begin : g_slot
      assign slot_hit[k] = (pos_q == POS_W'(IDLE_OFS + k * IDLE_GAP));
   end

   assign dec_stb  = run && (pos_q == POS_W'(DEC_OFS));
   assign idle_stb = run && (|slot_hit);
   assign lost     = run && (pos_q == POS_W'(TIMEOUT));
   assign acquire  = bit_valid && accept && !locked_q;
   assign locked   = locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q    <= POS_W'(POS_MAX);
         locked_q <= 1'b0;
      end else if (bit_valid) begin
         if (accept) begin
            pos_q    <= '0;
            locked_q <= 1'b1;
         end else begin
            if (pos_q != POS_W'(POS_MAX)) pos_q <= pos_q + POS_W'(1);
            if (lost) locked_q <= 1'b0;
         end
      end
   end

   // R4
   lock_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q && !(bit_valid && pos_q == POS_W'(TIMEOUT))) |=> locked_q);

   // R4
   lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_q) |-> ($past(pos_q) == POS_W'(TIMEOUT)));

   // R1
   lock_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && accept) |=> (locked_q && pos_q == '0));

endmodule

// File: rtl/fst_status_regs.sv
module fst_status_regs #(
   parameter int IDLE_VOTES = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bit_in,
   input  logic                      accept_stb,
   input  logic [fst_pkg::ERR_W-1:0] err_cnt,
   input  logic                      locked,
   input  logic                      acquire,
   input  logic                      dec_stb,
   input  logic                      idle_stb,
   output fst_pkg::stat_t            stat,
   output logic                      idle_upd
);
   import fst_pkg::*;

   if (IDLE_VOTES < 3 || (IDLE_VOTES % 2) == 0) begin : g_votes_bad
      $error("IDLE_VOTES must be odd and at least 3");
   end

   logic [IDLE_VOTES-1:0] hist_q;
   logic [IDLE_VOTES-1:0] hist_nxt;
   logic [ERR_W-1:0]      err_q;
   logic                  dec_q;
   logic                  busy_q;

   function automatic logic vote(input logic [IDLE_VOTES-1:0] v);
      return $countones(v) > (IDLE_VOTES / 2);
   endfunction

   assign hist_nxt = {hist_q[IDLE_VOTES-2:0], bit_in};
   assign idle_upd = idle_stb || acquire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         err_q  <= '0;
         dec_q  <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         if (accept_stb) err_q <= err_cnt;
         if (dec_stb) dec_q <= bit_in;
         if (idle_stb) begin
            hist_q <= hist_nxt;
            busy_q <= vote(hist_nxt);
         end else if (acquire) begin
            busy_q <= vote(hist_q);
         end
      end
   end

   assign stat = '{lock: locked, dec_fail: dec_q, busy: busy_q, rsvd: 2'b00, errs: err_q};

   // R3
   errs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !accept_stb |=> $stable(err_q));

   // R5
   dec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |=> $stable(dec_q));

   // R6
   busy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!locked && !acquire) |=> $stable(busy_q));

endmodule

// File: rtl/fst_irq.sv
module fst_irq #(
   parameter int NFLAG = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set,
   input  logic [NFLAG-1:0] clr,
   input  logic [NFLAG-1:0] en,
   output logic [NFLAG-1:0] flags,
   output logic             irq
);
   logic [NFLAG-1:0] flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr) | set;
   end

   assign flags = flags_q;
   assign irq   = |(flags_q & en);

   for (genvar i = 0; i < NFLAG; i++) begin : g_chk
      // R8
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flags_q[i] && !clr[i]) |=> flags_q[i]);
      // R8
      flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flags_q[i]);
   end

endmodule

// File: rtl/fwd_sync_tracker.sv
module fwd_sync_tracker #(
   parameter int                  SYNC_LEN   = 6,
   parameter logic [SYNC_LEN-1:0] SYNC_WORD  = 6'b101101,
   parameter int                  TIMEOUT    = 420,
   parameter int                  DEC_OFS    = 8,
   parameter int                  IDLE_OFS   = 12,
   parameter int                  IDLE_GAP   = 6,
   parameter int                  IDLE_VOTES = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_valid,
   input  logic       bit_in,
   input  logic [2:0] err_limit,
   input  logic [2:0] irq_en,
   input  logic [2:0] irq_clr,
   output logic [7:0] status,
   output logic [2:0] irq_flags,
   output logic       irq
);
   import fst_pkg::*;

   logic             accept;
   logic [ERR_W-1:0] err_cnt;
   logic             locked;
   logic             acquire;
   logic             lost;
   logic             dec_stb;
   logic             idle_stb;
   logic             idle_upd;
   stat_t            stat;
   logic [FLAG_W-1:0] flag_set;

   fst_sync_detect #(
      .SYNC_LEN  (SYNC_LEN),
      .SYNC_WORD (SYNC_WORD)
   ) i_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_valid (bit_valid),
      .bit_in    (bit_in),
      .err_limit (err_limit),
      .accept    (accept),
      .err_cnt   (err_cnt)
   );

   fst_frame_timer #(
      .TIMEOUT    (TIMEOUT),
      .DEC_OFS    (DEC_OFS),
      .IDLE_OFS   (IDLE_OFS),
      .IDLE_GAP   (IDLE_GAP),
      .IDLE_VOTES (IDLE_VOTES)
   ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_valid (bit_valid),
      .accept    (accept),
      .locked    (locked),
      .acquire   (acquire),
      .lost      (lost),
      .dec_stb   (dec_stb),
      .idle_stb  (idle_stb)
   );

   fst_status_regs #(
      .IDLE_VOTES (IDLE_VOTES)
   ) i_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_in     (bit_in),
      .accept_stb (accept),
      .err_cnt    (err_cnt),
      .locked     (locked),
      .acquire    (acquire),
      .dec_stb    (dec_stb),
      .idle_stb   (idle_stb),
      .stat       (stat),
      .idle_upd   (idle_upd)
   );

   always_comb begin
      flag_set          = '0;
      flag_set[FL_SEEN] = accept;
      flag_set[FL_IDLE] = idle_upd;
      flag_set[FL_LOST] = lost;
   end

   fst_irq #(
      .NFLAG (FLAG_W)
   ) i_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (irq_clr),
      .en    (irq_en),
      .flags (irq_flags),
      .irq   (irq)
   );

   assign status = stat;

   // R11
   quiet_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid |=> $stable(status));

endmodule

// File: tb/test_fwd_sync_tracker.sv
module test_fwd_sync_tracker;

   localparam logic [5:0] SW = 6'b101101;
   localparam int TMO  = 420;
   localparam int DOFS = 8;
   localparam int IOFS = 12;
   localparam int IGAP = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_valid = 1'b0;
   logic       bit_in = 1'b0;
   logic [2:0] err_limit = 3'd1;
   logic [2:0] irq_en = 3'd0;
   logic [2:0] irq_clr = 3'd0;
   logic [7:0] status;
   logic [2:0] irq_flags;
   logic       irq;

   int n_chk = 0;
   int n_err = 0;

   // reference model state
   logic [4:0] m_win = '0;
   int         m_fill = 0;
   logic       m_lock = 1'b0;
   int         m_pos = TMO + 1;
   logic [2:0] m_errs = '0;
   logic       m_dec = 1'b0;
   logic       m_busy = 1'b0;
   logic [4:0] m_hist = '0;
   logic [2:0] m_flags = '0;

   always #5 clk = ~clk;

   fwd_sync_tracker i_fwd_sync_tracker (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_valid (bit_valid),
      .bit_in    (bit_in),
      .err_limit (err_limit),
      .irq_en    (irq_en),
      .irq_clr   (irq_clr),
      .status    (status),
      .irq_flags (irq_flags),
      .irq       (irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic maj5(input logic [4:0] v);
      return $countones(v) >= 3;
   endfunction

   function automatic logic is_slot(input int p);
      return (p >= IOFS) && ((p - IOFS) % IGAP == 0) && ((p - IOFS) / IGAP < 5);
   endfunction

   task automatic model_bit(input logic b, input logic [2:0] clr);
      logic [5:0] w;
      int         e;
      logic [2:0] st;
      w  = {m_win, b};
      e  = $countones(w ^ SW);
      st = '0;
      if (m_fill >= 5 && e <= int'(err_limit)) begin
         st[0] = 1'b1;
         m_errs = 3'(e);
         if (!m_lock) begin
            m_busy = maj5(m_hist);
            st[1] = 1'b1;
         end
         m_lock = 1'b1;
         m_pos = 0;
      end else begin
         if (m_lock) begin
            if (m_pos == DOFS) m_dec = b;
            if (is_slot(m_pos)) begin
               m_hist = {m_hist[3:0], b};
               m_busy = maj5(m_hist);
               st[1] = 1'b1;
            end
            if (m_pos == TMO) begin
               m_lock = 1'b0;
               st[2] = 1'b1;
            end
         end
         if (m_pos < TMO + 1) m_pos++;
      end
      m_win = w[4:0];
      if (m_fill < 5) m_fill++;
      m_flags = (m_flags & ~clr) | st;
   endtask

   task automatic compare();
      chk("R1", {7'd0, status[7]}, {7'd0, m_lock});
      chk("R3", {5'd0, status[2:0]}, {5'd0, m_errs});
      chk("R5", {7'd0, status[6]}, {7'd0, m_dec});
      chk("R6", {7'd0, status[5]}, {7'd0, m_busy});
      chk("R10", {6'd0, status[4:3]}, 8'd0);
      chk("R8", {5'd0, irq_flags}, {5'd0, m_flags});
      chk("R9", {7'd0, irq}, {7'd0, |(m_flags & irq_en)});
   endtask

   task automatic send_bit(input logic b, input logic [2:0] clr);
      bit_valid = 1'b1;
      bit_in    = b;
      irq_clr   = clr;
      model_bit(b, clr);
      @(posedge clk);
      @(negedge clk);
      bit_valid = 1'b0;
      irq_clr   = '0;
      compare();
   endtask

   task automatic send_word(input logic [5:0] w);
      for (int i = 5; i >= 0; i--) send_bit(w[i], 3'b000);
   endtask

   task automatic send_zeros(input int n);
      for (int i = 0; i < n; i++) send_bit(1'b0, 3'b000);
   endtask

   task automatic send_frame(input logic d, input logic [4:0] idl);
      for (int p = 0; p < 40; p++) begin
         logic b;
         b = 1'b0;
         if (p == DOFS) b = d;
         if (is_slot(p)) b = idl[(p - IOFS) / IGAP];
         send_bit(b, 3'b000);
      end
   endtask

   task automatic clear_flags(input logic [2:0] c);
      irq_clr = c;
      m_flags = m_flags & ~c;
      @(posedge clk);
      @(negedge clk);
      irq_clr = '0;
      compare();
   endtask

   task automatic t_reset();
      chk("R10", status, 8'h00);
      chk("R10", {5'd0, irq_flags}, 8'h00);
      chk("R10", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_acquire();
      err_limit = 3'd1;
      send_zeros(10);
      chk("R1", {7'd0, status[7]}, 8'h00);
      send_word(SW);
      chk("R7", status, 8'h80);
      chk("R7", {5'd0, irq_flags}, 8'h03);
   endtask

   task automatic t_irq();
      irq_en = 3'b100;
      #1 chk("R9", {7'd0, irq}, 8'h00);
      irq_en = 3'b010;
      #1 chk("R9", {7'd0, irq}, 8'h01);
      clear_flags(3'b010);
      chk("R8", {5'd0, irq_flags}, 8'h01);
      chk("R9", {7'd0, irq}, 8'h00);
      clear_flags(3'b111);
      irq_en = 3'b111;
   endtask

   task automatic t_frame();
      send_frame(1'b1, 5'b11011);
      chk("R5", {7'd0, status[6]}, 8'h01);
      chk("R6", {7'd0, status[5]}, 8'h01);
      chk("R6", {7'd0, irq_flags[1]}, 8'h01);
      send_word(SW);
      chk("R1", {7'd0, status[7]}, 8'h01);
   endtask

   task automatic t_errors();
      clear_flags(3'b111);
      send_zeros(10);
      send_word(6'b101100);
      chk("R3", {5'd0, status[2:0]}, 8'h01);
      chk("R1", {7'd0, irq_flags[0]}, 8'h01);
      send_frame(1'b0, 5'b00100);
      clear_flags(3'b111);
      send_word(6'b100100);
      chk("R2", {5'd0, status[2:0]}, 8'h01);
      chk("R2", {7'd0, irq_flags[0]}, 8'h00);
      send_zeros(10);
      err_limit = 3'd2;
      send_word(6'b100100);
      chk("R3", {5'd0, status[2:0]}, 8'h02);
      err_limit = 3'd1;
      send_zeros(10);
      for (int i = 5; i >= 1; i--) send_bit(SW[i], 3'b000);
      send_bit(SW[0], 3'b001);
      chk("R8", {7'd0, irq_flags[0]}, 8'h01);
      chk("R3", {5'd0, status[2:0]}, 8'h00);
   endtask

   task automatic t_quiet();
      logic [7:0] s0;
      logic [2:0] f0;
      s0 = status;
      f0 = irq_flags;
      for (int i = 0; i < 30; i++) begin
         bit_in = SW[5 - (i % 6)];
         @(posedge clk);
         @(negedge clk);
      end
      chk("R11", status, s0);
      chk("R11", {5'd0, irq_flags}, {5'd0, f0});
      send_zeros(3);
   endtask

   task automatic t_timeout();
      send_word(SW);
      send_frame(1'b1, 5'b11111);
      chk("R6", {7'd0, status[5]}, 8'h01);
      clear_flags(3'b111);
      send_zeros(TMO - 40);
      chk("R4", {7'd0, status[7]}, 8'h01);
      send_bit(1'b0, 3'b000);
      chk("R4", {7'd0, status[7]}, 8'h00);
      chk("R4", {7'd0, irq_flags[2]}, 8'h01);
      for (int i = 0; i < 40; i++) send_bit(i % 7 == 3, 3'b000);
      chk("R5", {7'd0, status[6]}, 8'h01);
      chk("R6", {7'd0, status[5]}, 8'h01);
      clear_flags(3'b111);
      send_zeros(4);
      send_word(SW);
      chk("R7", {7'd0, status[5]}, 8'h01);
      chk("R7", {7'd0, irq_flags[1]}, 8'h01);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_acquire();
      t_irq();
      t_frame();
      t_errors();
      t_quiet();
      t_timeout();
      finish_run();
   end

endmodule